// File: doc/BRIEF.md
# Queued Serial Master Controller

This block is a four-wire, full-duplex serial master that works through a list of transfers held in an internal sixteen-slot queue. Software fills the slots through a write port. Each slot holds a transmit word, which of four targets to select, how many bits to exchange (1 to 16) and how long the bus must stay quiet afterwards. Once enabled, the controller takes the slots in order with no per-transfer help. It drives the serial clock, the outgoing data line and one active-low select line per target. It captures the incoming line and keeps each received word in a receive register that belongs to the same slot.

Two modes are available. A single pass stops after the programmed last slot and raises a completion flag. Wrap mode returns to slot 0 and keeps cycling until it is disabled, so software only needs to refresh transmit words and collect received words now and then. When enable is cleared, the current transfer finishes, all selects go high and no further slot starts. The clock mode has the clock idle low, data launched while the clock is low and the input sampled on the rising edge. The half-period is `clk_div + 1` system clocks, so the clock period is 2*(clk_div+1) system clocks.

Top module: `qspi_master`

## Requirements
- R1: A write with `wr_en` high stores `wr_tx`, `wr_cs`, `wr_len` and `wr_dly` into slot `wr_idx`, and that slot's next transfer uses those values.
- R2: During a transfer, exactly the select `cs_n[k]` is low, where k is the slot's 2-bit select index. At all other times every bit of `cs_n` is 1.
- R3: `sclk` is low whenever no select is asserted. A slot with length field L produces exactly L+1 clock pulses, each high for `clk_div+1` cycles and low for `clk_div+1` cycles.
- R4: `mosi` carries the low L+1 bits of the transmit word, most significant of those first. It changes only while `sclk` is low and is 0 whenever no select is asserted.
- R5: `miso` is sampled on each rising `sclk` edge. The L+1 received bits, right-aligned with zeros above them, are stored in the receive register of the same slot, and `rd_data` shows the register chosen by `rd_idx` in the same cycle.
- R6: The select goes low `clk_div+1` cycles before the first rising `sclk` edge and stays low for `clk_div+1` cycles after the last falling edge.
- R7: Between two transfers, all selects stay high for exactly D+2 system clocks, where D is the 8-bit delay field of the slot just finished.
- R8: `done` is high for exactly one cycle, the first cycle after the select is released, and `done_idx` then gives the slot that finished.
- R9: With `wrap` low, slots 0 through `last_idx` run once in order. `qcomplete` then rises in the cycle after the last slot's quiet interval and stays high. No new transfer starts until `enable` has been low.
- R10: With `wrap` high, slot `last_idx` is followed by slot 0, and transfers continue without software action.
- R11: Clearing `enable` lets the running transfer and its quiet interval complete. After that no transfer starts, every select stays high and `qcomplete` clears. The next enable starts again at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Queue slot write strobe |
| wr_idx | input | 4 | Slot written |
| wr_tx | input | 16 | Transmit word |
| wr_cs | input | 2 | Target select index |
| wr_len | input | 4 | Bit count minus one |
| wr_dly | input | 8 | Quiet interval field |
| enable | input | 1 | Run the queue |
| wrap | input | 1 | Wrap-around continuous mode |
| last_idx | input | 4 | Final slot of a pass |
| clk_div | input | 8 | Half-period minus one, in system clocks |
| rd_idx | input | 4 | Receive register select |
| rd_data | output | 16 | Receive register contents |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low target selects |
| done | output | 1 | One-cycle end-of-transfer pulse |
| done_idx | output | 4 | Slot that just finished |
| qcomplete | output | 1 | Single pass finished |

## Verification
The queue is exercised with four mixes of slot contents:
- Full 16-bit words, single-bit words and mid-length words, with every select index and with zero and non-zero quiet intervals. This mix separates bit-order and bit-count errors from select decoding.
- The same structure at a slower clock divider. This exposes errors that only appear when a half-period lasts more than one system clock.
- Wrap-around runs that are stopped partway through a pass. These tell the return to slot 0 apart from a stop after `last_idx`, and show whether the disable waits for the transfer boundary.
- A restart after disable. This confirms the pointer returns to slot 0.

The incoming line carries words that differ from the outgoing ones. The receive registers are read back afterwards, which shows whether each word was stored in the correct slot and aligned correctly.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
    parameter int DATA_W = 16;
    parameter int DEPTH  = 16;
    parameter int NCS    = 4;
    parameter int DLY_W  = 8;
    parameter int DIV_W  = 8;

    localparam int IDX_W = $clog2(DEPTH);
    localparam int LEN_W = $clog2(DATA_W);
    localparam int CS_W  = $clog2(NCS);

    typedef struct packed {
        logic [DATA_W-1:0] tx;
        logic [CS_W-1:0]   cs;
        logic [LEN_W-1:0]  len;
        logic [DLY_W-1:0]  dly;
    } slot_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOW,
        S_HIGH,
        S_HOLD,
        S_GAP
    } phase_t;

    function automatic logic [NCS-1:0] sel_lines(input logic [CS_W-1:0] idx,
                                                  input logic active);
        logic [NCS-1:0] v;
        v = '1;
        if (active) v[idx] = 1'b0;
        return v;
    endfunction
endpackage

// File: rtl/qspi_slots.sv
module qspi_slots import qspi_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  slot_t             wr_slot,
    input  logic [IDX_W-1:0]  run_idx,
    output slot_t             run_slot,
    input  logic              rx_we,
    input  logic [DATA_W-1:0] rx_word,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_word
);
    slot_t             slot_q [DEPTH];
    logic [DATA_W-1:0] rx_q   [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[i] <= '0;
                rx_q[i]   <= '0;
            end else begin
                if (wr_en && wr_idx == IDX_W'(i)) slot_q[i] <= wr_slot;
                if (rx_we && run_idx == IDX_W'(i)) rx_q[i] <= rx_word;
            end
        end
    end

    assign run_slot = slot_q[run_idx];
    assign rd_word  = rx_q[rd_idx];
endmodule

// File: rtl/qspi_halfper.sv
module qspi_halfper import qspi_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/qspi_engine.sv
module qspi_engine import qspi_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              wrap,
    input  logic [IDX_W-1:0]  last_idx,
    input  slot_t             cur,
    input  logic              tick,
    input  logic              miso,
    output logic              run,
    output logic [IDX_W-1:0]  ptr,
    output logic              rx_we,
    output logic [DATA_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi,
    output logic [NCS-1:0]    cs_n,
    output logic              done,
    output logic              qcomplete
);
    phase_t            ph;
    logic [DATA_W-1:0] sh;
    logic [LEN_W-1:0]  bits_left;
    logic [CS_W-1:0]   cs_idx;
    logic [DLY_W-1:0]  gap_cnt;

    assign run     = (ph == S_LOW) || (ph == S_HIGH) || (ph == S_HOLD);
    assign sclk    = (ph == S_HIGH);
    assign mosi    = run && sh[DATA_W-1];
    assign cs_n    = sel_lines(cs_idx, run);
    assign rx_we   = (ph == S_HOLD) && tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= S_IDLE;
            ptr       <= '0;
            sh        <= '0;
            rx_word   <= '0;
            bits_left <= '0;
            cs_idx    <= '0;
            gap_cnt   <= '0;
            done      <= 1'b0;
            qcomplete <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (ph)
                S_IDLE: begin
                    if (!enable) begin
                        ptr       <= '0;
                        qcomplete <= 1'b0;
                    end else if (!qcomplete) begin
                        // DATA_W is a power of two, so ~len == DATA_W-1-len
                        sh        <= cur.tx << (~cur.len);
                        bits_left <= cur.len;
                        cs_idx    <= cur.cs;
                        gap_cnt   <= cur.dly;
                        rx_word   <= '0;
                        ph        <= S_LOW;
                    end
                end
                S_LOW: if (tick) begin
                    rx_word <= {rx_word[DATA_W-2:0], miso};
                    ph      <= S_HIGH;
                end
                S_HIGH: if (tick) begin
                    if (bits_left == '0) begin
                        ph <= S_HOLD;
                    end else begin
                        sh        <= sh << 1;
                        bits_left <= bits_left - 1'b1;
                        ph        <= S_LOW;
                    end
                end
                S_HOLD: if (tick) begin
                    done <= 1'b1;
                    ph   <= S_GAP;
                end
                S_GAP: begin
                    if (gap_cnt == '0) begin
                        ph <= S_IDLE;
                        if (ptr == last_idx) begin
                            ptr <= '0;
                            if (!wrap) qcomplete <= 1'b1;
                        end else begin
                            ptr <= ptr + 1'b1;
                        end
                    end else begin
                        gap_cnt <= gap_cnt - 1'b1;
                    end
                end
                default: ph <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/qspi_master.sv
module qspi_master import qspi_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_tx,
    input  logic [CS_W-1:0]   wr_cs,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [DLY_W-1:0]  wr_dly,
    input  logic              enable,
    input  logic              wrap,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NCS-1:0]    cs_n,
    output logic              done,
    output logic [IDX_W-1:0]  done_idx,
    output logic              qcomplete
);
    slot_t             wr_slot, cur;
    logic [IDX_W-1:0]  ptr;
    logic              run, tick, rx_we;
    logic [DATA_W-1:0] rx_word;

    assign wr_slot  = '{tx: wr_tx, cs: wr_cs, len: wr_len, dly: wr_dly};
    assign done_idx = ptr;

    qspi_slots u_slots (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_slot(wr_slot),
        .run_idx(ptr), .run_slot(cur), .rx_we(rx_we), .rx_word(rx_word),
        .rd_idx(rd_idx), .rd_word(rd_data)
    );

    qspi_halfper u_half (
        .clk(clk), .rst(rst), .run(run), .div(clk_div), .tick(tick)
    );

    qspi_engine u_eng (
        .clk(clk), .rst(rst), .enable(enable), .wrap(wrap), .last_idx(last_idx),
        .cur(cur), .tick(tick), .miso(miso), .run(run), .ptr(ptr),
        .rx_we(rx_we), .rx_word(rx_word), .sclk(sclk), .mosi(mosi),
        .cs_n(cs_n), .done(done), .qcomplete(qcomplete)
    );
endmodule

// File: rtl/qspi_master_chk.sv
module qspi_master_chk import qspi_pkg::*; (
    input logic           clk,
    input logic           rst,
    input logic [NCS-1:0] cs_n,
    input logic           sclk,
    input logic           mosi,
    input logic           done,
    input logic           qcomplete
);
    p_one_select_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n) <= 1);

    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (&cs_n) |-> !sclk);

    p_mosi_steady_r4: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(mosi));

    p_release_low_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(&cs_n) |-> (!sclk && !$past(sclk)));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_released_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> &cs_n);

    p_complete_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        qcomplete |-> &cs_n);
endmodule

bind qspi_master qspi_master_chk u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .done(done), .qcomplete(qcomplete)
);

// File: tb/test_qspi_master.sv
module test_qspi_master;
    logic        clk = 0, rst = 1;
    logic        wr_en = 0;
    logic [3:0]  wr_idx = 0;
    logic [15:0] wr_tx = 0;
    logic [1:0]  wr_cs = 0;
    logic [3:0]  wr_len = 0;
    logic [7:0]  wr_dly = 0;
    logic        enable = 0, wrap = 0, miso = 0;
    logic [3:0]  last_idx = 0, rd_idx = 0;
    logic [7:0]  clk_div = 0;
    logic [15:0] rd_data;
    logic        sclk, mosi, done, qcomplete;
    logic [3:0]  cs_n, done_idx;

    int vectors = 0, miscompares = 0;
    bit finished = 0;
    logic exp_qc = 0;
    logic [15:0] m_tx [16];
    logic [1:0]  m_cs [16];
    logic [3:0]  m_len [16];
    logic [7:0]  m_dly [16];
    logic [15:0] m_slv [16];

    always #10 clk = ~clk;

    qspi_master i_qspi_master (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tx(wr_tx),
        .wr_cs(wr_cs), .wr_len(wr_len), .wr_dly(wr_dly), .enable(enable),
        .wrap(wrap), .last_idx(last_idx), .clk_div(clk_div), .rd_idx(rd_idx),
        .rd_data(rd_data), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
        .done(done), .done_idx(done_idx), .qcomplete(qcomplete)
    );

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    task automatic step(input logic [3:0] ecs, input logic esclk, input logic chk_m,
                        input logic em, input logic edone, input int eidx, input string rq);
        @(negedge clk);
        vectors++;
        if (cs_n !== ecs || sclk !== esclk || done !== edone || qcomplete !== exp_qc ||
            (chk_m && mosi !== em) || (edone && done_idx !== 4'(eidx))) begin
            miscompares++;
            $display("FAIL %s: got cs_n=%b sclk=%b mosi=%b done=%b qc=%b idx=%0d, expected cs_n=%b sclk=%b mosi=%b done=%b qc=%b idx=%0d",
                     rq, cs_n, sclk, mosi, done, qcomplete, done_idx,
                     ecs, esclk, em, edone, exp_qc, eidx);
        end
    endtask

    task automatic put(input int k, input logic [15:0] tx, input logic [1:0] cs,
                       input logic [3:0] len, input logic [7:0] dly, input logic [15:0] slv);
        @(negedge clk);
        wr_en = 1; wr_idx = 4'(k); wr_tx = tx; wr_cs = cs; wr_len = len; wr_dly = dly;
        m_tx[k] = tx; m_cs[k] = cs; m_len[k] = len; m_dly[k] = dly; m_slv[k] = slv;
        @(negedge clk);
        wr_en = 0;
    endtask

    // One queue slot, from its first select-low cycle to the idle cycle after its gap
    task automatic run_slot(input int k, input int h, input bit ends_pass, input bit drop_en);
        logic [3:0] ecs;
        int n;
        ecs = ~(4'b0001 << m_cs[k]);
        n = int'(m_len[k]) + 1;
        for (int b = 0; b < n; b++) begin
            miso = m_slv[k][n-1-b];
            for (int c = 0; c < h; c++) begin
                step(ecs, 0, 1, m_tx[k][n-1-b], 0, 0, "R1 R2 R4 R6 low phase");
                if (drop_en) begin enable = 0; drop_en = 0; end
            end
            for (int c = 0; c < h; c++) step(ecs, 1, 1, m_tx[k][n-1-b], 0, 0, "R3 R4 high phase");
        end
        for (int c = 0; c < h; c++) step(ecs, 0, 0, 0, 0, 0, "R6 hold");
        step(4'hF, 0, 1, 0, 1, k, "R8 done");
        for (int c = 0; c < int'(m_dly[k]); c++) step(4'hF, 0, 1, 0, 0, 0, "R7 gap");
        if (ends_pass) exp_qc = 1;
        step(4'hF, 0, 1, 0, 0, 0, "R7 R9 idle");
    endtask

    task automatic check_rx(input int k);
        logic [15:0] e;
        @(negedge clk);
        rd_idx = 4'(k);
        #1;
        e = m_slv[k] & 16'((17'h1 << (int'(m_len[k]) + 1)) - 1);
        vectors++;
        if (rd_data !== e) begin
            miscompares++;
            $display("FAIL R5 slot %0d: got %h expected %h", k, rd_data, e);
        end
    endtask

    initial begin
        #(200000 * 20);
        miscompares++;
        $display("FAIL watchdog: got no end, expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        step(4'hF, 0, 1, 0, 0, 0, "R2 R3 reset state");

        // Single pass, fastest clock, mixed lengths and selects
        put(0, 16'hA5C3, 2, 15, 0, 16'h3C96);
        put(1, 16'h0001, 0, 0,  3, 16'h0001);
        put(2, 16'h0055, 3, 7,  1, 16'h00F0);
        put(3, 16'h0012, 1, 4,  5, 16'h0015);
        clk_div = 0; last_idx = 3; wrap = 0;
        @(negedge clk); enable = 1;
        for (int k = 0; k < 4; k++) run_slot(k, 1, k == 3, 0);
        for (int i = 0; i < 8; i++) step(4'hF, 0, 1, 0, 0, 0, "R9 no restart");
        for (int k = 0; k < 4; k++) check_rx(k);
        @(negedge clk); enable = 0; exp_qc = 0;
        step(4'hF, 0, 1, 0, 0, 0, "R11 qcomplete clears");

        // Single pass, slower clock
        put(0, 16'h0ABC, 1, 11, 2, 16'h0F0F);
        put(1, 16'h0005, 0, 2,  0, 16'h0002);
        clk_div = 2; last_idx = 1;
        @(negedge clk); enable = 1;
        run_slot(0, 3, 0, 0);
        run_slot(1, 3, 1, 0);
        check_rx(0); check_rx(1);
        @(negedge clk); enable = 0; exp_qc = 0;
        step(4'hF, 0, 1, 0, 0, 0, "R11 qcomplete clears");

        // Wrap mode, stopped during slot 0 of the third pass
        clk_div = 1; last_idx = 2; wrap = 1;
        put(2, 16'h0033, 3, 5, 1, 16'h002A);
        @(negedge clk); enable = 1;
        for (int p = 0; p < 7; p++) run_slot(p % 3, 2, 0, p == 6);
        for (int i = 0; i < 12; i++) step(4'hF, 0, 1, 0, 0, 0, "R10 R11 stopped");
        check_rx(0); check_rx(1); check_rx(2); check_rx(3);

        // Restart after disable begins at slot 0
        wrap = 0; last_idx = 0; clk_div = 0;
        put(0, 16'h8001, 2, 15, 0, 16'h7FFE);
        @(negedge clk); enable = 1;
        run_slot(0, 1, 1, 0);
        check_rx(0);
        summary();
    end
endmodule